// File: doc/BRIEF.md
# Stepped Reversible Set/Clear Latch

This block models a set/clear storage cell built from two three-line reversible gates, with the stored value carried by gate outputs that are fed back to the gate inputs on the next step. Each rising clock edge outside reset is one gate-processing step. On that step the control lines, two constant lines tied to 1 and the stored pair (q, q_n) pass through both gates, and the selected outputs become the new stored pair. No line fans out.

A parameter picks the gate family. The Fredkin form behaves as a cross-coupled NOR pair with active-high controls. The Toffoli form behaves as a cross-coupled NAND pair with active-low controls. Besides the stored pair, the block exposes the two spare gate lines, a flag that marks a step which left the state unchanged, a saturating count of state-changing steps since the controls last moved, and a flag for period-two oscillation. All pins are plain level signals, sampled on every edge with no handshake and no back-pressure. The block is meant for characterising settle latency and illegal-state behaviour before a clocked storage element is built on top of it.

Top module: `revsr_latch`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) loads q=0, q_n=1 and clears settled, steps and osc.
- R2: With VARIANT=VAR_FREDKIN a control is active when its line is 1; with VARIANT=VAR_TOFFOLI a control is active when its line is 0. Idle lines are 00 and 11 respectively.
- R3: With both controls idle and a complementary stored pair (q,q_n = 01 or 10), every step keeps the pair unchanged.
- R4: With both controls idle and a non-complementary pair (00 or 11), every step flips the pair between 00 and 11.
- R5: With only set active, the pair reaches 10 within two steps from any start and then stays; with only clear active it reaches 01 likewise. Starts that need two steps: for set, 01 and 11 (Fredkin) or 01 and 00 (Toffoli); for clear, 10 and 11 (Fredkin) or 10 and 00 (Toffoli).
- R6: With both controls active, one step drives the pair to 00 (Fredkin) or 11 (Toffoli), and it stays there.
- R7: garbage[0] and garbage[1] are the spare lines of the q-side and q_n-side gates for the present inputs and state: Fredkin gives garbage[0] = clear active ? q_n : 1 and garbage[1] = set active ? q : 1; Toffoli gives garbage[0] = q_n and garbage[1] = q.
- R8: settled is 1 after a step exactly when that step left the pair unchanged.
- R9: steps counts state-changing steps since the control lines last changed; a step on which the lines differ from the previous step restarts it at 1 if the pair changed and 0 otherwise. It saturates at 7 (2^CNT_W-1).
- R10: osc is 1 after a step that changed the pair back to the value it had two steps earlier while the control lines were equal on both steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock; one gate-processing step per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| set_line | input | 1 | Set control line, polarity per variant |
| clr_line | input | 1 | Clear control line, polarity per variant |
| q | output | 1 | Stored value |
| q_n | output | 1 | Stored complement line |
| garbage | output | 2 | Spare gate outputs of the current step |
| settled | output | 1 | Last step left the pair unchanged |
| steps | output | CNT_W | Saturating count of state-changing steps since controls moved |
| osc | output | 1 | Period-two oscillation detected |

## Verification
The multi-step properties assume the control lines stay constant across the edges they span and that reset is asserted before the first edge; the properties on settle time also assume no reset fell inside the window. The stimulus changes control lines only at falling edges and holds each setting for whole steps, and every starting pair is reached through the block's own behaviour from reset (reset, set, both-active and idle steps), so no state is forced. Both variants are driven in lockstep with logically equal control activity, which shows the polarity difference at the pins.

// File: rtl/revsr_pkg.sv
`timescale 1ns/1ps
package revsr_pkg;
  typedef enum logic {
    VAR_FREDKIN = 1'b0,
    VAR_TOFFOLI = 1'b1
  } revsr_variant_e;

  typedef struct packed {
    logic q;
    logic qn;
  } revsr_state_t;

  localparam revsr_state_t ST_RESET = '{q: 1'b0, qn: 1'b1};
endpackage

// File: rtl/revsr_toffoli_gate.sv
`timescale 1ns/1ps
module revsr_toffoli_gate (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic ya,
  output logic yb,
  output logic yc
);
  // controlled-controlled inversion of the third line
  assign ya = a;
  assign yb = b;
  assign yc = (a & b) ^ c;
endmodule

// File: rtl/revsr_fredkin_gate.sv
`timescale 1ns/1ps
module revsr_fredkin_gate (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic ya,
  output logic yb,
  output logic yc
);
  // controlled exchange of the two target lines
  assign ya = a;
  assign yb = a ? c : b;
  assign yc = a ? b : c;
endmodule

// File: rtl/revsr_step_core.sv
`timescale 1ns/1ps
module revsr_step_core
  import revsr_pkg::*;
#(
  parameter revsr_variant_e VARIANT = VAR_FREDKIN
) (
  input  logic         s_line,
  input  logic         r_line,
  input  revsr_state_t cur,
  output revsr_state_t nxt,
  output logic [1:0]   garb
);
  localparam logic ANC = 1'b1;

  logic pa_ctl, pb_ctl;
  logic a_mid, a_out, b_mid, b_out;

  generate
    if (VARIANT == VAR_TOFFOLI) begin : g_tof
      // q side: NAND of set-bar and q_n on the target line
      revsr_toffoli_gate u_ga (.a(s_line), .b(cur.qn), .c(ANC),
                               .ya(pa_ctl), .yb(a_mid), .yc(a_out));
      revsr_toffoli_gate u_gb (.a(r_line), .b(cur.q), .c(ANC),
                               .ya(pb_ctl), .yb(b_mid), .yc(b_out));
      assign nxt.q  = a_out;
      assign nxt.qn = b_out;
      assign garb   = {b_mid, a_mid};
    end else begin : g_fred
      // q side: exchange gives clear OR q_n, inverted on the way out
      revsr_fredkin_gate u_ga (.a(r_line), .b(cur.qn), .c(ANC),
                               .ya(pa_ctl), .yb(a_mid), .yc(a_out));
      revsr_fredkin_gate u_gb (.a(s_line), .b(cur.q), .c(ANC),
                               .ya(pb_ctl), .yb(b_mid), .yc(b_out));
      assign nxt.q  = ~a_mid;
      assign nxt.qn = ~b_mid;
      assign garb   = {b_out, a_out};
    end
  endgenerate

  // R7: control lines leave each gate unchanged
  always_comb begin
    a_r7_ctrl_lines_pass: assert ((VARIANT == VAR_TOFFOLI)
        ? (pa_ctl == s_line && pb_ctl == r_line)
        : (pa_ctl == r_line && pb_ctl == s_line))
      else $error("control line altered by gate");
  end
endmodule

// File: rtl/revsr_watch.sv
`timescale 1ns/1ps
module revsr_watch
  import revsr_pkg::*;
#(
  parameter int         CNT_W     = 3,
  parameter logic [1:0] IDLE_CTRL = 2'b00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ctrl,
  input  revsr_state_t     cur,
  input  revsr_state_t     nxt,
  output logic             settled,
  output logic [CNT_W-1:0] steps,
  output logic             osc
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [1:0]   ctrl_prev;
  revsr_state_t hist;
  logic         chg, moved;

  assign chg   = (ctrl != ctrl_prev);
  assign moved = (nxt != cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_prev <= IDLE_CTRL;
      hist      <= ST_RESET;
      settled   <= 1'b0;
      steps     <= '0;
      osc       <= 1'b0;
    end else begin
      ctrl_prev <= ctrl;
      hist      <= cur;
      settled   <= ~moved;
      osc       <= moved && (nxt == hist) && !chg;
      if (chg)
        steps <= moved ? CNT_ONE : '0;
      else if (moved && steps != CNT_MAX)
        steps <= steps + CNT_ONE;
    end
  end

  a_r8_settled_same: assert property (@(posedge clk) disable iff (rst)
    settled |-> $stable(cur));
  a_r9_restart_on_change: assert property (@(posedge clk) disable iff (rst)
    chg |=> (steps <= CNT_ONE));
  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    (steps == CNT_MAX && !chg) |=> (steps == CNT_MAX));
  a_r10_osc_noncomp: assert property (@(posedge clk) disable iff (rst)
    osc |-> (cur.q == cur.qn) && !settled);
endmodule

// File: rtl/revsr_latch.sv
`timescale 1ns/1ps
module revsr_latch
  import revsr_pkg::*;
#(
  parameter revsr_variant_e VARIANT = VAR_FREDKIN,
  parameter int             CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_line,
  input  logic             clr_line,
  output logic             q,
  output logic             q_n,
  output logic [1:0]       garbage,
  output logic             settled,
  output logic [CNT_W-1:0] steps,
  output logic             osc
);
  localparam logic       ACT_LVL = (VARIANT == VAR_TOFFOLI) ? 1'b0 : 1'b1;
  localparam logic [1:0] IDLE    = {~ACT_LVL, ~ACT_LVL};
  localparam logic       BOTH_V  = (VARIANT == VAR_TOFFOLI) ? 1'b1 : 1'b0;

  revsr_state_t st, st_nxt;
  logic act_s, act_c;

  revsr_step_core #(.VARIANT(VARIANT)) u_core (
    .s_line(set_line), .r_line(clr_line), .cur(st), .nxt(st_nxt), .garb(garbage)
  );

  revsr_watch #(.CNT_W(CNT_W), .IDLE_CTRL(IDLE)) u_watch (
    .clk(clk), .rst(rst), .ctrl({set_line, clr_line}), .cur(st), .nxt(st_nxt),
    .settled(settled), .steps(steps), .osc(osc)
  );

  always_ff @(posedge clk) begin
    if (rst) st <= ST_RESET;
    else     st <= st_nxt;
  end

  assign q     = st.q;
  assign q_n   = st.qn;
  assign act_s = (set_line == ACT_LVL);
  assign act_c = (clr_line == ACT_LVL);

  a_r3_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    (!act_s && !act_c && q != q_n) |=> ($stable(q) && $stable(q_n)));
  a_r4_hold_toggles: assert property (@(posedge clk) disable iff (rst)
    (!act_s && !act_c && q == q_n) |=> (q != $past(q) && q == q_n));
  a_r6_both_active: assert property (@(posedge clk) disable iff (rst)
    (act_s && act_c) |=> (q == BOTH_V && q_n == BOTH_V));
  a_r5_set_two_steps: assert property (@(posedge clk) disable iff (rst)
    (act_s && !act_c && $past(act_s && !act_c) && !$past(rst)) |=> (q && !q_n));
  a_r5_clr_two_steps: assert property (@(posedge clk) disable iff (rst)
    (act_c && !act_s && $past(act_c && !act_s) && !$past(rst)) |=> (!q && q_n));
endmodule

// File: tb/revsr_latch_bench.sv
`timescale 1ns/1ps
module revsr_latch_bench;
  import revsr_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic as_i = 1'b0;
  logic ac_i = 1'b0;
  int   total = 0;
  int   bad   = 0;

  always #4 clk = ~clk;

  logic       qf, qnf, sf, of, qt, qnt, stt, ot;
  logic [1:0] gf, gt;
  logic [2:0] cf, ct;

  revsr_latch #(.VARIANT(VAR_FREDKIN), .CNT_W(3)) u_revsr_latch (
    .clk(clk), .rst(rst), .set_line(as_i), .clr_line(ac_i),
    .q(qf), .q_n(qnf), .garbage(gf), .settled(sf), .steps(cf), .osc(of));

  revsr_latch #(.VARIANT(VAR_TOFFOLI), .CNT_W(3)) u_revsr_latch_tof (
    .clk(clk), .rst(rst), .set_line(~as_i), .clr_line(~ac_i),
    .q(qt), .q_n(qnt), .garbage(gt), .settled(stt), .steps(ct), .osc(ot));

  // reference model, index 0 = Fredkin, 1 = Toffoli
  logic [1:0] m_st[2], m_hist[2], m_prev[2];
  logic [2:0] m_cnt[2];
  logic       m_set[2], m_osc[2];

  function automatic logic [1:0] ref_next(int v, logic s, logic c, logic [1:0] x);
    if (v == 0) return {~(c | x[0]), ~(s | x[1])};
    return {s | ~x[0], c | ~x[1]};
  endfunction

  function automatic logic [1:0] ref_garb(int v, logic s, logic c, logic [1:0] x);
    if (v == 0) return {s ? x[1] : 1'b1, c ? x[0] : 1'b1};
    return {x[1], x[0]};
  endfunction

  function automatic logic [8:0] got_vec(int v);
    if (v == 0) return {qf, qnf, gf, sf, cf, of};
    return {qt, qnt, gt, stt, ct, ot};
  endfunction

  task automatic model_reset();
    for (int v = 0; v < 2; v++) begin
      m_st[v] = 2'b01; m_hist[v] = 2'b01; m_prev[v] = 2'b00;
      m_cnt[v] = 3'd0; m_set[v] = 1'b0; m_osc[v] = 1'b0;
    end
  endtask

  task automatic model_step(logic s, logic c);
    for (int v = 0; v < 2; v++) begin
      logic [1:0] n;
      logic chg, mv;
      n   = ref_next(v, s, c, m_st[v]);
      chg = ({s, c} != m_prev[v]);
      mv  = (n != m_st[v]);
      m_set[v] = ~mv;
      m_osc[v] = mv && (n == m_hist[v]) && !chg;
      if (chg) m_cnt[v] = mv ? 3'd1 : 3'd0;
      else if (mv && m_cnt[v] != 3'd7) m_cnt[v] = m_cnt[v] + 3'd1;
      m_hist[v] = m_st[v];
      m_prev[v] = {s, c};
      m_st[v]   = n;
    end
  endtask

  task automatic chk(string tag, int v, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s variant=%0d got=%0h exp=%0h", tag, v, got, exp);
    end
  endtask

  // one step; called just after a falling edge, returns after the next one
  task automatic step(logic s, logic c);
    as_i = s; ac_i = c;
    @(negedge clk);
    model_step(s, c);
  endtask

  task automatic do_reset();
    rst = 1'b1; as_i = 1'b0; ac_i = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic cmp_model(string tag);
    for (int v = 0; v < 2; v++)
      chk(tag, v, {7'd0, got_vec(v)},
          {7'd0, m_st[v], ref_garb(v, as_i, ac_i, m_st[v]), m_set[v], m_cnt[v], m_osc[v]});
  endtask

  task automatic chk_pair(string tag, logic [1:0] ef, logic [1:0] et);
    chk(tag, 0, {14'd0, qf, qnf}, {14'd0, ef});
    chk(tag, 1, {14'd0, qt, qnt}, {14'd0, et});
  endtask

  task automatic chk_cnt(string tag, logic [2:0] e);
    chk(tag, 0, {13'd0, cf}, {13'd0, e});
    chk(tag, 1, {13'd0, ct}, {13'd0, e});
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset state", 0, {11'd0, qf, qnf, sf, cf}, {11'd0, 2'b01, 1'b0, 3'd0});
    chk("R1 reset state", 1, {11'd0, qt, qnt, stt, ct}, {11'd0, 2'b01, 1'b0, 3'd0});
    chk("R1 reset osc", 0, {15'd0, of}, 16'd0);
    chk("R1 reset osc", 1, {15'd0, ot}, 16'd0);
  endtask

  task automatic t_hold_keep();
    do_reset();
    step(1'b0, 1'b0); step(1'b0, 1'b0);
    chk_pair("R3 hold 01", 2'b01, 2'b01);
    chk("R8 settled on hold", 0, {15'd0, sf}, 16'd1);
    chk("R8 settled on hold", 1, {15'd0, stt}, 16'd1);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
    step(1'b0, 1'b0); step(1'b0, 1'b0);
    chk_pair("R3 hold 10", 2'b10, 2'b10);
    chk_cnt("R9 change without move", 3'd0);
  endtask

  task automatic t_set_paths();
    do_reset();
    step(1'b1, 1'b0);
    chk_pair("R2 R5 set first step from 01", 2'b00, 2'b11);
    chk_cnt("R9 first step count", 3'd1);
    step(1'b1, 1'b0);
    chk_pair("R5 set second step from 01", 2'b10, 2'b10);
    step(1'b1, 1'b0);
    chk_pair("R5 set stays", 2'b10, 2'b10);
    chk_cnt("R9 set from 01 took two", 3'd2);
    chk("R8 settled after set", 0, {15'd0, sf}, 16'd1);
    chk("R8 settled after set", 1, {15'd0, stt}, 16'd1);
    do_reset();
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    chk_pair("R5 set one step from both-active state", 2'b10, 2'b10);
    chk_cnt("R9 one step", 3'd1);
  endtask

  task automatic t_clr_paths();
    do_reset();
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    chk_pair("R5 clear first step from 10", 2'b00, 2'b11);
    step(1'b0, 1'b1); step(1'b0, 1'b1);
    chk_pair("R5 clear ends 01", 2'b01, 2'b01);
    chk_cnt("R9 clear from 10 took two", 3'd2);
  endtask

  task automatic t_both();
    do_reset();
    step(1'b1, 1'b1);
    chk_pair("R6 both active", 2'b00, 2'b11);
    step(1'b1, 1'b1);
    chk_pair("R6 both active stable", 2'b00, 2'b11);
    chk("R8 settled both", 0, {15'd0, sf}, 16'd1);
    chk("R8 settled both", 1, {15'd0, stt}, 16'd1);
  endtask

  task automatic t_hold_toggle();
    do_reset();
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    chk_pair("R4 toggle step1", 2'b11, 2'b00);
    chk("R10 no osc on change", 0, {15'd0, of}, 16'd0);
    step(1'b0, 1'b0);
    chk_pair("R4 toggle step2", 2'b00, 2'b11);
    chk("R10 osc", 0, {15'd0, of}, 16'd1);
    chk("R10 osc", 1, {15'd0, ot}, 16'd1);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
    chk_cnt("R9 saturates", 3'd7);
    chk("R10 osc held", 0, {15'd0, of}, 16'd1);
  endtask

  task automatic t_garb();
    do_reset();
    as_i = 1'b1; ac_i = 1'b0;
    #1;
    chk("R7 garbage set active", 0, {14'd0, gf}, 16'b01);
    chk("R7 garbage set active", 1, {14'd0, gt}, 16'b01);
    as_i = 1'b0; ac_i = 1'b1;
    #1;
    chk("R7 garbage clear active", 0, {14'd0, gf}, 16'b11);
    chk("R7 garbage clear active", 1, {14'd0, gt}, 16'b01);
    as_i = 1'b0; ac_i = 1'b0;
    @(negedge clk);
    model_step(1'b0, 1'b0);
  endtask

  task automatic prep(int route);
    do_reset();
    case (route)
      1: begin step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0); end
      2: step(1'b1, 1'b1);
      3: begin step(1'b1, 1'b1); step(1'b0, 1'b0); end
      default: ;
    endcase
  endtask

  // all four control settings against all four start pairs, per variant
  task automatic t_sweep();
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 4; k++) begin
        prep(r);
        for (int n = 0; n < 4; n++) begin
          step(k[1], k[0]);
          cmp_model("R3 R4 R5 R6 R7 R8 R9 R10 sweep");
        end
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_hold_keep();
    t_set_paths();
    t_clr_paths();
    t_both();
    t_hold_toggle();
    t_garb();
    t_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule